// File: doc/BRIEF.md
# Double-Buffered DAC Channel Register Bank

This block sits behind a two-wire serial slave and turns the bytes it receives into settings for a bank of 8-bit DAC channels. The slave front end reports three bus events as one-cycle pulses: a START, a match of its own address, and a STOP. It then delivers the received payload bytes on a valid/ready byte stream. Inside an addressed transaction the bytes alternate between two kinds. A command byte selects a channel and carries a reset flag and a power-down flag. The output byte that follows it is the new value for the selected channel.

Each channel has two registers. The input latch receives output bytes while the transaction runs. The output latch drives the converter. At the STOP that ends an addressed transaction, every output latch copies its input latch in the same cycle, so all channels change together. The power-down and reset flags are also acted on only at that STOP, and only the values from the last command byte count. A reset clears both registers of every channel and takes priority over the copy. A transaction cut short by a new START loses its pending flags but keeps whatever it wrote into the input latches.

The stream accepts a byte only inside an addressed transaction. Outside one, `in_ready` stays low and the offered byte is held upstream rather than dropped. The channel count `NCH` is a parameter and must be a power of two from 2 to 8. With fewer than eight channels, the high select bits are ignored.

Top module: `dac_latch_bank`

## Requirements
- R1: While `rst_n` is low and after it rises, every channel word on `dac_words` is 0x00 and `power_down` is 0.
- R2: The first byte accepted after `addr_match` is a command byte, and accepted bytes then alternate command/output. In a command byte, bit 4 is the reset flag and bit 3 is the power-down flag. Bits 2:0 select the channel, and only the low log2(NCH) of them are used. Bits 7:5 have no effect. A command byte that is the last byte before STOP writes no channel.
- R3: An output byte is written to the input latch of the channel chosen by the preceding command byte. `dac_words` does not change before the STOP.
- R4: When `stop_seen` pulses during an addressed transaction, every output latch copies its input latch, and `dac_words` shows the new values in the cycle after the pulse. At no other time does `dac_words` change, except through reset.
- R5: A byte accepted in the same cycle as `stop_seen` belongs to the transaction. A command byte there counts as the last command. An output byte there is included in the copy.
- R6: At STOP, `power_down` takes the power-down flag of the last command byte of the transaction. A transaction without any command byte leaves `power_down` unchanged.
- R7: While `power_down` is 1, writes and STOP copies still update the latches. When power-down is cleared, `dac_words` shows the current output-latch contents.
- R8: If the last command byte has the reset flag set, the STOP clears the input and output latches of all channels to 0x00. This overrides the copy, including any output byte that arrived after that command.
- R9: A `start_seen` pulse during a transaction ends it with no copy, and its pending power-down and reset flags are discarded. Its input-latch writes remain and are copied at the next addressed STOP.
- R10: `in_ready` is 1 only inside an addressed transaction, and not in a cycle where `addr_match` or `start_seen` is high. A byte offered while `in_ready` is 0 is not consumed and does not change any state.
- R11: With NCH=4, command bit 2 is ignored, so select values 5 and 1 address the same channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_match | input | 1 | Pulse: the slave recognised its address, a transaction begins |
| start_seen | input | 1 | Pulse: a START was seen on the bus |
| stop_seen | input | 1 | Pulse: a STOP was seen on the bus |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready |
| in_data | input | 8 | Received byte |
| dac_words | output | NCH*8 | Output-latch words, channel i in bits [8i+7:8i] |
| power_down | output | 1 | 1 while the converter is powered down |

## Verification
The collision that matters is a byte handshake in the same cycle as the STOP pulse. There, the last write or the last command must land in the commit that the STOP triggers. The bench provokes this with a final output byte driven together with `stop_seen`. In a separate case, a reset command is followed by a data byte and then a STOP, and the data must lose to the reset. A cycle-by-cycle behavioural model is compared with `dac_words`, `power_down` and `in_ready` on every clock. A second instance with four channels runs on the same stimulus to judge that the top select bit is ignored.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;

  localparam int BYTE_W      = 8;
  localparam int CMD_RST_BIT = 4;
  localparam int CMD_PD_BIT  = 3;
  localparam int CMD_SEL_W   = 3;

  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } byte_phase_e;

  typedef struct packed {
    logic                 rst;
    logic                 pd;
    logic [CMD_SEL_W-1:0] sel;
  } cmd_fields_t;

  function automatic cmd_fields_t decode_cmd(input logic [BYTE_W-1:0] b);
    cmd_fields_t f;
    f.rst = b[CMD_RST_BIT];
    f.pd  = b[CMD_PD_BIT];
    f.sel = b[CMD_SEL_W-1:0];
    return f;
  endfunction

endpackage

// File: rtl/dac_cmd_parse.sv
module dac_cmd_parse
  import dac_bank_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_match,
  input  logic              start_seen,
  input  logic              stop_seen,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              wr_en,
  output logic [SEL_W-1:0]  wr_sel,
  output logic [BYTE_W-1:0] wr_data,
  output logic              commit,
  output logic              clr,
  output logic              pd_load,
  output logic              pd_val
);

  byte_phase_e      phase_q;
  logic             sess_q;
  logic             pend_any_q, pend_pd_q, pend_rst_q;
  logic             pend_any_nx, pend_pd_nx, pend_rst_nx;
  logic [SEL_W-1:0] sel_q;
  logic             accept, take_cmd, take_dat;
  cmd_fields_t      cmd;

  assign in_ready = sess_q & ~addr_match & ~start_seen;
  assign accept   = in_valid & in_ready;
  assign take_cmd = accept & (phase_q == PH_CMD);
  assign take_dat = accept & (phase_q == PH_DATA);
  assign cmd      = decode_cmd(in_data);

  // a command in the same cycle as STOP still counts as the last one
  always_comb begin
    pend_any_nx = pend_any_q;
    pend_pd_nx  = pend_pd_q;
    pend_rst_nx = pend_rst_q;
    if (take_cmd) begin
      pend_any_nx = 1'b1;
      pend_pd_nx  = cmd.pd;
      pend_rst_nx = cmd.rst;
    end
  end

  assign commit  = stop_seen & sess_q;
  assign clr     = commit & pend_rst_nx;
  assign pd_load = commit & pend_any_nx;
  assign pd_val  = pend_pd_nx;
  assign wr_en   = take_dat;
  assign wr_sel  = sel_q;
  assign wr_data = in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_CMD;
      sess_q     <= 1'b0;
      sel_q      <= '0;
      pend_any_q <= 1'b0;
      pend_pd_q  <= 1'b0;
      pend_rst_q <= 1'b0;
    end else begin
      if (take_cmd) sel_q <= cmd.sel[SEL_W-1:0];
      if (accept) phase_q <= (phase_q == PH_CMD) ? PH_DATA : PH_CMD;
      if (addr_match) phase_q <= PH_CMD;
      if (addr_match || start_seen || stop_seen) begin
        pend_any_q <= 1'b0;
        pend_pd_q  <= 1'b0;
        pend_rst_q <= 1'b0;
      end else begin
        pend_any_q <= pend_any_nx;
        pend_pd_q  <= pend_pd_nx;
        pend_rst_q <= pend_rst_nx;
      end
      sess_q <= addr_match | (sess_q & ~stop_seen & ~start_seen);
    end
  end

  // R2: a match always restarts byte parity on a command byte
  a_r2_phase_cmd_after_match: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match |=> (phase_q == PH_CMD));

  // R9: an abort leaves nothing pending and no open session
  a_r9_abort_drops_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (start_seen && !addr_match) |=> (!pend_any_q && !pend_rst_q && !sess_q));

  // R10: nothing is accepted outside a transaction
  a_r10_no_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sess_q |-> !(take_cmd || take_dat));

endmodule

// File: rtl/dac_channel.sv
module dac_channel
  import dac_bank_pkg::*;
#(
  parameter int IDX   = 0,
  parameter int SEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              commit,
  input  logic              clr,
  output logic [BYTE_W-1:0] out_word
);

  localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(IDX);

  logic [BYTE_W-1:0] in_q, in_nx, out_q;

  always_comb begin
    in_nx = in_q;
    if (wr_en && wr_sel == MY_SEL) in_nx = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      out_q <= '0;
    end else if (clr) begin
      in_q  <= '0;
      out_q <= '0;
    end else begin
      in_q <= in_nx;
      if (commit) out_q <= in_nx;
    end
  end

  assign out_word = out_q;

  // R4: the output latch moves only on a commit
  a_r4_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(out_q));

  // R8: a reset commit clears both latches
  a_r8_clear_both: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (out_q == '0 && in_q == '0));

endmodule

// File: rtl/dac_pd_ctrl.sv
module dac_pd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_load,
  input  logic pd_val,
  output logic power_down
);

  logic pd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pd_q <= 1'b0;
    else if (pd_load) pd_q <= pd_val;
  end

  assign power_down = pd_q;

  // R6: power-down changes only at a STOP that carried a command
  a_r6_pd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_load |=> $stable(pd_q));

endmodule

// File: rtl/dac_latch_bank.sv
module dac_latch_bank
  import dac_bank_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  addr_match,
  input  logic                  start_seen,
  input  logic                  stop_seen,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [BYTE_W-1:0]     in_data,
  output logic [NCH*BYTE_W-1:0] dac_words,
  output logic                  power_down
);

  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic              wr_en, commit, clr, pd_load, pd_val;
  logic [SEL_W-1:0]  wr_sel;
  logic [BYTE_W-1:0] wr_data;

  dac_cmd_parse #(.SEL_W(SEL_W)) u_parse (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_match (addr_match),
    .start_seen (start_seen),
    .stop_seen  (stop_seen),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .commit     (commit),
    .clr        (clr),
    .pd_load    (pd_load),
    .pd_val     (pd_val)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dac_channel #(.IDX(g), .SEL_W(SEL_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .commit   (commit),
      .clr      (clr),
      .out_word (dac_words[g*BYTE_W +: BYTE_W])
    );
  end

  dac_pd_ctrl u_pd (
    .clk        (clk),
    .rst_n      (rst_n),
    .pd_load    (pd_load),
    .pd_val     (pd_val),
    .power_down (power_down)
  );

  // R1: the reset state holds while reset is applied
  always_comb begin
    if (!rst_n) a_r1_reset_state: assert (power_down == 1'b0);
  end

endmodule

// File: tb/test_dac_latch_bank.sv
`timescale 1ns/1ps
module test_dac_latch_bank;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic am = 1'b0, ss = 1'b0, sp = 1'b0, iv = 1'b0;
  logic [7:0] id = 8'h00;
  logic rdy8, rdy4, pd8, pd4;
  logic [63:0] w8;
  logic [31:0] w4;

  always #2.5 clk = ~clk;

  dac_latch_bank #(.NCH(8)) i_dac_latch_bank (
    .clk(clk), .rst_n(rst_n), .addr_match(am), .start_seen(ss), .stop_seen(sp),
    .in_valid(iv), .in_ready(rdy8), .in_data(id), .dac_words(w8), .power_down(pd8));

  dac_latch_bank #(.NCH(4)) i_dac_latch_bank_q (
    .clk(clk), .rst_n(rst_n), .addr_match(am), .start_seen(ss), .stop_seen(sp),
    .in_valid(iv), .in_ready(rdy4), .in_data(id), .dac_words(w4), .power_down(pd4));

  // behavioural reference
  logic [7:0] m_in8 [8], m_out8 [8], m_in4 [4], m_out4 [4];
  bit m_pd, m_sess, m_ppd, m_prst, m_pany;
  int m_phase, m_sel;
  int n_vec = 0, n_bad = 0;
  string tag = "R1";
  bit done = 0;

  function automatic bit exp_ready();
    return m_sess && !am && !ss;
  endfunction

  task automatic model_clear_pending();
    m_ppd = 0; m_prst = 0; m_pany = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_in8[i] = 0; m_out8[i] = 0; end
      for (int i = 0; i < 4; i++) begin m_in4[i] = 0; m_out4[i] = 0; end
      m_pd = 0; m_sess = 0; m_phase = 0; m_sel = 0;
      model_clear_pending();
    end else begin
      bit acc;
      acc = iv && exp_ready();
      if (acc) begin
        if (m_phase == 0) begin
          m_sel = int'(id[2:0]); m_pd_pend(id);
          m_phase = 1;
        end else begin
          m_in8[m_sel] = id;
          m_in4[m_sel % 4] = id;
          m_phase = 0;
        end
      end
      if (sp && m_sess) begin
        if (m_prst) begin
          for (int i = 0; i < 8; i++) begin m_in8[i] = 0; m_out8[i] = 0; end
          for (int i = 0; i < 4; i++) begin m_in4[i] = 0; m_out4[i] = 0; end
        end else begin
          for (int i = 0; i < 8; i++) m_out8[i] = m_in8[i];
          for (int i = 0; i < 4; i++) m_out4[i] = m_in4[i];
        end
        if (m_pany) m_pd = m_ppd;
      end
      if (sp || ss) begin m_sess = 0; model_clear_pending(); end
      if (am) begin m_sess = 1; m_phase = 0; model_clear_pending(); end
    end
  end

  task automatic m_pd_pend(input logic [7:0] b);
    m_ppd = b[3]; m_prst = b[4]; m_pany = 1;
  endtask

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // compare every clock, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (!done) begin
      for (int i = 0; i < 8; i++) chk(tag, int'(w8[i*8 +: 8]), int'(m_out8[i]), $sformatf("ch%0d/8", i));
      for (int i = 0; i < 4; i++) chk(tag, int'(w4[i*8 +: 8]), int'(m_out4[i]), $sformatf("ch%0d/4", i));
      chk(tag, int'(pd8), int'(m_pd), "pd/8");
      chk(tag, int'(pd4), int'(m_pd), "pd/4");
      chk(tag, int'(rdy8), int'(exp_ready()), "ready/8");
      chk(tag, int'(rdy4), int'(exp_ready()), "ready/4");
    end
  end

  task automatic drive(input bit a, input bit s, input bit p, input bit v, input logic [7:0] d);
    @(negedge clk);
    am = a; ss = s; sp = p; iv = v; id = d;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 8'h00);
  endtask
  task automatic begin_txn(); drive(1, 1, 0, 0, 8'h00); drive(1, 0, 0, 0, 8'h00); endtask
  task automatic put(input logic [7:0] b); drive(0, 0, 0, 1, b); endtask
  task automatic end_txn(); drive(0, 0, 1, 0, 8'h00); idle(2); endtask

  task automatic expect_word(input string req, input int ch, input int exp);
    @(negedge clk);
    chk(req, int'(w8[ch*8 +: 8]), exp, $sformatf("direct ch%0d", ch));
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    tag = "R1";
    idle(3);
    chk("R1", int'(w8), 0, "reset words");
    rst_n = 1'b1;
    idle(2);

    // R2 / R3 / R4: three channels staged, outputs move only at STOP
    tag = "R3";
    begin_txn();
    put(8'h00); put(8'hFF); put(8'h02); put(8'h80); put(8'h01); put(8'hFF);
    idle(2);
    expect_word("R3", 0, 0);
    tag = "R4";
    end_txn();
    expect_word("R4", 0, 8'hFF);
    expect_word("R4", 1, 8'hFF);
    expect_word("R4", 2, 8'h80);

    // R2: reserved bits set, select 5
    tag = "R2";
    begin_txn(); put(8'hE5); put(8'h3C); end_txn();
    expect_word("R2", 5, 8'h3C);

    // R6: lone PD command, then an empty transaction
    tag = "R6";
    begin_txn(); put(8'h08); end_txn();
    begin_txn(); end_txn();

    // R7: write while powered down, then resume with a lone command selecting 7
    tag = "R7";
    begin_txn(); put(8'h0C); put(8'h55); end_txn();
    expect_word("R7", 4, 8'h55);
    begin_txn(); put(8'h07); end_txn();
    expect_word("R7", 7, 8'h00);
    expect_word("R7", 4, 8'h55);

    // R5: final output byte in the STOP cycle
    tag = "R5";
    begin_txn(); put(8'h06); drive(0, 0, 1, 1, 8'h99); idle(2);
    expect_word("R5", 6, 8'h99);

    // R9: abort with reset+pd pending, then commit the kept write
    tag = "R9";
    begin_txn(); put(8'h03); put(8'h77); put(8'h18); drive(0, 1, 0, 0, 8'h00); idle(2);
    expect_word("R9", 3, 8'h00);
    begin_txn(); put(8'h00); end_txn();
    expect_word("R9", 3, 8'h77);

    // R8: reset wins over a later output byte
    tag = "R8";
    begin_txn(); put(8'h01); put(8'h44); put(8'h11); put(8'h22); end_txn();
    expect_word("R8", 0, 8'h00);
    expect_word("R8", 3, 8'h00);

    // R10: byte offered while idle and across the match cycle
    tag = "R10";
    drive(0, 0, 0, 1, 8'hAB); drive(0, 0, 0, 1, 8'hAB);
    drive(0, 1, 0, 1, 8'hAB); drive(1, 0, 0, 1, 8'hAB);
    drive(0, 0, 0, 1, 8'hAB);
    put(8'h5E); end_txn();
    expect_word("R10", 3, 8'h5E);

    // R11: select 5 lands on channel 1 of the four-channel bank
    tag = "R11";
    begin_txn(); put(8'h05); put(8'h5A); put(8'h00); end_txn();
    @(negedge clk);
    chk("R11", int'(w4[8 +: 8]), 8'h5A, "quad ch1");
    chk("R11", int'(w8[40 +: 8]), 8'h5A, "octal ch5");

    idle(3);
    finish_run();
  end

endmodule